// File: doc/BRIEF.md
# Serial Bitstream Configuration Loader

This block configures a target FPGA through its one-bit slave-serial port. A local agent starts a load with a byte count; the bytes then come in on a valid/ready stream. The block drives the target's program request, its configuration clock and one data line, and it reads back the target's INIT (active low) and DONE pins.

A load runs in this order. The block first holds the target in reset and waits for the INIT acknowledge. It then releases reset and waits for INIT to clear. It shifts each byte out most significant bit first. Before every byte it checks INIT for a CRC error. After the data it keeps the clock running with the data line high until DONE rises. Each run ends with exactly one single-cycle result pulse: done, fail or crc error. The target does not support readback on this port, so a readback request is refused with a fail pulse.

The timeout, the delay before reset is released and the configuration clock half-period are all parameters counted in system clock cycles.

Top module: `cfg_serial_loader`

## Requirements
- R1: Out of reset and whenever no load is running, `cfg_prog_o` is 0, `s_ready_o` is 0, `cfg_cclk_o` is 0 and no result pulse is high.
- R2: A `start_i` pulse while idle sets `cfg_prog_o` to 1 (1 = target held in reset). If `cfg_init_n_i` has not gone to 0 within TIMEOUT_CYC cycles, `fail_o` pulses between TIMEOUT_CYC and TIMEOUT_CYC+2 cycles after `cfg_prog_o` rose, and `cfg_prog_o` returns to 0.
- R3: Once `cfg_init_n_i` is 0, `cfg_prog_o` stays 1 for at least PROG_DELAY_CYC more cycles and then drops to 0. If `cfg_init_n_i` does not return to 1 within TIMEOUT_CYC cycles, `fail_o` pulses between TIMEOUT_CYC and TIMEOUT_CYC+2 cycles after `cfg_prog_o` fell.
- R4: Each byte goes out as 8 bits, bit 7 first. `cfg_din_o` changes only while `cfg_cclk_o` is 0, so the target captures each bit on a rising clock edge. Every low phase of `cfg_cclk_o` that starts with a falling edge lasts exactly HALF_CYC cycles.
- R5: `s_ready_o` is high only while the block waits for the next byte, with `cfg_prog_o` at 0. Exactly `length_i` bytes (the value latched at start) are taken from the stream. A gap in `s_valid_i` stalls the load without losing or repeating a byte.
- R6: Before each byte, if `cfg_init_n_i` is 0 while `cfg_done_i` is 0, the block pulses `crc_err_o`, takes no further bytes and returns to idle.
- R7: After the last byte, including a load of length 0, `cfg_din_o` is 1 on every further rising edge of `cfg_cclk_o`. The clock keeps toggling until `cfg_done_i` is seen high; then `done_o` pulses.
- R8: If `cfg_done_i` stays 0 for TIMEOUT_CYC cycles after the last byte, `fail_o` pulses and the block returns to idle.
- R9: `readback_i` while idle produces a `fail_o` pulse on the next cycle and does not start a load (`cfg_prog_o` stays 0).
- R10: `done_o`, `fail_o` and `crc_err_o` are one-cycle pulses. At most one of them is high in any cycle, and exactly one is produced per started load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin a configuration load (idle only) |
| readback_i | input | 1 | Readback request; always refused |
| length_i | input | LEN_W | Number of bitstream bytes, latched at start |
| s_data_i | input | 8 | Stream byte |
| s_valid_i | input | 1 | Stream byte valid |
| s_ready_o | output | 1 | Block accepts a byte this cycle |
| cfg_prog_o | output | 1 | Target reset request, 1 = asserted |
| cfg_cclk_o | output | 1 | Configuration clock to target |
| cfg_din_o | output | 1 | Serial configuration data to target |
| cfg_init_n_i | input | 1 | Target INIT, 0 = asserted |
| cfg_done_i | input | 1 | Target DONE, 1 = configured |
| done_o | output | 1 | Pulse: load completed |
| fail_o | output | 1 | Pulse: timeout or refused readback |
| crc_err_o | output | 1 | Pulse: target reported a CRC error |

## Verification
The bench builds the block with HALF_CYC=2, TIMEOUT_CYC=64, PROG_DELAY_CYC=3 and LEN_W=4. With these values every timeout fires within a few dozen cycles, and the full length range from 0 to 15 bytes can be swept. A behavioural target model answers the handshake after chosen delays, captures the serial bits on rising edges and raises DONE after a chosen number of extra clocks. It can also signal a CRC error after any byte position of a 4-byte load. Throttled stream validity, corner byte values (0x80, 0x01, 0xFF, 0x00), each of the three timeouts and the readback refusal are all covered.

// File: rtl/cfg_load_pkg.sv
// Shared types for the serial configuration loader.
// Assumes: nothing beyond IEEE 1800-2017.
package cfg_load_pkg;

    // Sequencer states of the loader
    typedef enum logic [2:0] {
        ST_IDLE,     // waiting for start or readback request
        ST_PROG,     // target held in reset, waiting for INIT low
        ST_HOLD,     // INIT seen low, reset kept for the set delay
        ST_RELEASE,  // reset released, waiting for INIT high
        ST_CHECK,    // byte boundary: count and CRC checks
        ST_FETCH,    // waiting for a stream byte
        ST_SHIFT,    // serialising one byte
        ST_FLUSH     // data high, clocking until DONE
    } ld_state_e;

endpackage

// File: rtl/cfg_wait_timer.sv
// Shared wait counter for the loader: a single saturating counter that
// restarts on every sequencer state change. It reports the timeout
// limit when the caller is in a state that watches for it, and it reports
// the reset-hold delay.
// Assumes: 1 <= DELAY_CYC < LIMIT_CYC, LIMIT_CYC >= 2.
module cfg_wait_timer #(
    parameter int LIMIT_CYC = 1250000,
    parameter int DELAY_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic watch_i,
    output logic expired_o,
    output logic delay_hit_o
);
    localparam int CW = $clog2(LIMIT_CYC + 1);
    localparam logic [CW-1:0] LAST  = CW'(LIMIT_CYC - 1);
    localparam logic [CW-1:0] DLAST = CW'(DELAY_CYC - 1);

    logic [CW-1:0] cnt_q;

    // Count cycles spent in the current state, saturating at the limit
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o   = watch_i && (cnt_q == LAST);
    assign delay_hit_o = (cnt_q == DLAST);

    // R8 (and R2, R3): a fresh wait can never expire on its first cycle
    a_r8_no_instant_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> !expired_o);

endmodule

// File: rtl/cfg_bit_serializer.sv
// Serial output stage: shifts one byte out MSB first on the configuration
// clock and, in flush mode, keeps the clock running with data held high.
// The clock idles low after clear; a byte starts with a low phase, and the
// data only changes at the falling edge. After the eighth bit the clock
// stays high until the next load or flush toggle.
// Assumes: load_i only while not busy; clear_i wins over everything.
module cfg_bit_serializer #(
    parameter int HALF_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear_i,
    input  logic       load_i,
    input  logic [7:0] byte_i,
    input  logic       flush_i,
    output logic       byte_done_o,
    output logic       cclk_o,
    output logic       din_o
);
    localparam int HW = $clog2(HALF_CYC + 1);
    localparam logic [HW-1:0] HLAST = HW'(HALF_CYC - 1);

    logic [7:0]    sh_q;
    logic [HW-1:0] hcnt_q;
    logic [2:0]    bit_q;
    logic          act_q;
    logic          hi_q;
    logic          cclk_q;
    logic          tick;

    assign tick = (hcnt_q == HLAST);

    // Half-period pacing, bit sequencing and flush clocking
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            sh_q   <= '0;
            hcnt_q <= '0;
            bit_q  <= '0;
            act_q  <= 1'b0;
            hi_q   <= 1'b0;
            cclk_q <= 1'b0;
        end else if (load_i) begin
            sh_q   <= byte_i;
            hcnt_q <= '0;
            bit_q  <= '0;
            act_q  <= 1'b1;
            hi_q   <= 1'b0;
            cclk_q <= 1'b0;
        end else if (act_q) begin
            if (tick) begin
                hcnt_q <= '0;
                if (!hi_q) begin
                    hi_q   <= 1'b1;
                    cclk_q <= 1'b1;
                end else if (bit_q == 3'd7) begin
                    act_q <= 1'b0;
                end else begin
                    bit_q  <= bit_q + 3'd1;
                    sh_q   <= {sh_q[6:0], 1'b0};
                    hi_q   <= 1'b0;
                    cclk_q <= 1'b0;
                end
            end else begin
                hcnt_q <= hcnt_q + 1'b1;
            end
        end else if (flush_i) begin
            if (tick) begin
                hcnt_q <= '0;
                cclk_q <= ~cclk_q;
            end else begin
                hcnt_q <= hcnt_q + 1'b1;
            end
            if (!cclk_q || tick) begin
                sh_q <= 8'hFF;
            end
        end
    end

    assign byte_done_o = act_q && hi_q && tick && (bit_q == 3'd7);
    assign cclk_o      = cclk_q;
    assign din_o       = sh_q[7];

    // R4: data may not move while the clock stays high
    a_r4_din_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (cclk_o && $past(cclk_o)) |-> $stable(din_o));

    // R7: once flushing with the clock low, the data line is high
    a_r7_flush_data_high: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_i && !clear_i && !cclk_o) |=> (din_o || !flush_i));

endmodule

// File: rtl/cfg_serial_loader.sv
// Slave-serial configuration loader (top). Sequences the target reset and
// INIT handshake, pulls bytes from a valid/ready stream, serialises them,
// checks INIT for a CRC error at each byte boundary and clocks the target
// until DONE. Readback requests are refused. One result pulse per run.
// Assumes: target pins are already synchronous to clk; start_i and
// readback_i are honoured only while idle.
module cfg_serial_loader
    import cfg_load_pkg::*;
#(
    parameter int LEN_W          = 16,
    parameter int HALF_CYC       = 4,
    parameter int TIMEOUT_CYC    = 1250000,
    parameter int PROG_DELAY_CYC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             readback_i,
    input  logic [LEN_W-1:0] length_i,
    input  logic [7:0]       s_data_i,
    input  logic             s_valid_i,
    output logic             s_ready_o,
    output logic             cfg_prog_o,
    output logic             cfg_cclk_o,
    output logic             cfg_din_o,
    input  logic             cfg_init_n_i,
    input  logic             cfg_done_i,
    output logic             done_o,
    output logic             fail_o,
    output logic             crc_err_o
);
    ld_state_e        st_q, st_d;
    logic [LEN_W-1:0] len_q, cnt_q;
    logic             done_q, fail_q, crc_q;
    logic             p_done, p_fail, p_crc;
    logic             ser_load, byte_done;
    logic             tmo_exp, delay_hit, tmo_watch;

    assign tmo_watch = (st_q == ST_PROG) || (st_q == ST_RELEASE) || (st_q == ST_FLUSH);

    // Next-state and result selection for the load sequence
    always_comb begin
        st_d     = st_q;
        p_done   = 1'b0;
        p_fail   = 1'b0;
        p_crc    = 1'b0;
        ser_load = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (readback_i)   p_fail = 1'b1;
                else if (start_i) st_d = ST_PROG;
            end
            ST_PROG: begin
                if (!cfg_init_n_i) begin
                    st_d = ST_HOLD;
                end else if (tmo_exp) begin
                    p_fail = 1'b1;
                    st_d   = ST_IDLE;
                end
            end
            ST_HOLD: begin
                if (delay_hit) st_d = ST_RELEASE;
            end
            ST_RELEASE: begin
                if (cfg_init_n_i) begin
                    st_d = ST_CHECK;
                end else if (tmo_exp) begin
                    p_fail = 1'b1;
                    st_d   = ST_IDLE;
                end
            end
            ST_CHECK: begin
                if (cnt_q == len_q) begin
                    st_d = ST_FLUSH;
                end else if (!cfg_init_n_i && !cfg_done_i) begin
                    p_crc = 1'b1;
                    st_d  = ST_IDLE;
                end else begin
                    st_d = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (s_valid_i) begin
                    ser_load = 1'b1;
                    st_d     = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (byte_done) st_d = ST_CHECK;
            end
            ST_FLUSH: begin
                if (cfg_done_i) begin
                    p_done = 1'b1;
                    st_d   = ST_IDLE;
                end else if (tmo_exp) begin
                    p_fail = 1'b1;
                    st_d   = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State, latched length, byte counter and registered result pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            len_q  <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
            fail_q <= 1'b0;
            crc_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            done_q <= p_done;
            fail_q <= p_fail;
            crc_q  <= p_crc;
            if (st_q == ST_IDLE && start_i && !readback_i) begin
                len_q <= length_i;
                cnt_q <= '0;
            end else if (ser_load) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    cfg_wait_timer #(
        .LIMIT_CYC (TIMEOUT_CYC),
        .DELAY_CYC (PROG_DELAY_CYC)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart_i   (st_d != st_q),
        .watch_i     (tmo_watch),
        .expired_o   (tmo_exp),
        .delay_hit_o (delay_hit)
    );

    cfg_bit_serializer #(
        .HALF_CYC (HALF_CYC)
    ) u_ser (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (st_q == ST_IDLE),
        .load_i      (ser_load),
        .byte_i      (s_data_i),
        .flush_i     (st_q == ST_FLUSH),
        .byte_done_o (byte_done),
        .cclk_o      (cfg_cclk_o),
        .din_o       (cfg_din_o)
    );

    assign s_ready_o  = (st_q == ST_FETCH);
    assign cfg_prog_o = (st_q == ST_PROG) || (st_q == ST_HOLD);
    assign done_o     = done_q;
    assign fail_o     = fail_q;
    assign crc_err_o  = crc_q;

    // R10: result pulses never overlap
    a_r10_pulse_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_o, fail_o, crc_err_o}));

    // R10: done is a single-cycle pulse
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R1: a result leaves the target out of reset and the stream closed
    a_r1_quiet_on_result: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || fail_o || crc_err_o) |-> (!cfg_prog_o && !s_ready_o));

    // R5: bytes are only accepted with the target out of reset
    a_r5_ready_released: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready_o |-> !cfg_prog_o);

    // R6: a CRC pulse follows INIT low with DONE low
    a_r6_crc_cause: assert property (@(posedge clk) disable iff (!rst_n)
        crc_err_o |-> $past(!cfg_init_n_i && !cfg_done_i));

    // R7: completion follows DONE seen high
    a_r7_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(cfg_done_i));

    // R9: readback in idle is refused on the next cycle
    a_r9_readback_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && readback_i) |=> fail_o);

endmodule

// File: tb/test_cfg_serial_loader.sv
module test_cfg_serial_loader;
    localparam int LW  = 4;
    localparam int HC  = 2;
    localparam int TMO = 64;
    localparam int DLY = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic rdbk = 1'b0;
    logic [LW-1:0] len_drv = '0;
    logic [7:0] sdata;
    logic svalid, sready, prog, cclk, din;
    logic init_n = 1'b1;
    logic tdone = 1'b0;
    logic done_p, fail_p, crc_p;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // stream source
    logic [7:0] mem [16];
    int src_idx = 0;
    int base = 0;
    int src_end = 0;
    bit thr = 1'b0;

    // target model configuration (written by tasks only)
    int m_gen = 0, m_len = 0, m_lo = 0, m_hi = 0, m_crck = -1, m_dn = 0;
    // target model state (written by model only)
    int m_seen = 0, stage = 0, mcnt = 0, bits = 0, post_rises = 0, post_zero = 0;
    int lowrun = 0, lowrun_bad = 0, cnt_done = 0, cnt_fail = 0, cnt_crc = 0;
    int t_prog_rise = -1, t_init_low = -1, t_prog_fall = -1, t_fail = -1;
    logic [7:0] rx [16];
    logic [7:0] mshr = '0;
    logic cclk_prev = 1'b0;

    always #4 clk = ~clk;

    assign svalid = (src_idx < src_end) && !(thr && (cyc % 3 == 0));
    assign sdata  = mem[(src_idx - base) & 15];

    always @(posedge clk) if (svalid && sready) src_idx <= src_idx + 1;

    cfg_serial_loader #(
        .LEN_W(LW), .HALF_CYC(HC), .TIMEOUT_CYC(TMO), .PROG_DELAY_CYC(DLY)
    ) i_cfg_serial_loader (
        .clk(clk), .rst_n(rst_n), .start_i(start), .readback_i(rdbk),
        .length_i(len_drv), .s_data_i(sdata), .s_valid_i(svalid), .s_ready_o(sready),
        .cfg_prog_o(prog), .cfg_cclk_o(cclk), .cfg_din_o(din),
        .cfg_init_n_i(init_n), .cfg_done_i(tdone),
        .done_o(done_p), .fail_o(fail_p), .crc_err_o(crc_p)
    );

    // Target model and monitors, sampled away from the active edge
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (m_gen != m_seen) begin
            m_seen = m_gen; stage = 0; mcnt = 0; bits = 0; post_rises = 0; post_zero = 0;
            lowrun = 0; lowrun_bad = 0; cnt_done = 0; cnt_fail = 0; cnt_crc = 0;
            t_prog_rise = -1; t_init_low = -1; t_prog_fall = -1; t_fail = -1;
            init_n = 1'b1; tdone = 1'b0; mshr = '0;
        end else begin
            if (done_p) cnt_done = cnt_done + 1;
            if (fail_p) begin cnt_fail = cnt_fail + 1; t_fail = cyc; end
            if (crc_p) cnt_crc = cnt_crc + 1;
            if (!cclk && cclk_prev) lowrun = 1;
            else if (!cclk && lowrun > 0) lowrun = lowrun + 1;
            case (stage)
                0: if (prog) begin stage = 1; mcnt = 0; t_prog_rise = cyc; end
                1: begin
                    if (!prog) stage = 9;
                    else begin
                        mcnt = mcnt + 1;
                        if (m_lo >= 0 && mcnt >= m_lo) begin
                            init_n = 1'b0; t_init_low = cyc; stage = 2;
                        end
                    end
                end
                2: if (!prog) begin t_prog_fall = cyc; stage = 3; mcnt = 0; end
                3: begin
                    mcnt = mcnt + 1;
                    if (m_hi >= 0 && mcnt >= m_hi) begin init_n = 1'b1; stage = 4; end
                end
                4: begin
                    if (m_crck == 0 && bits == 0) init_n = 1'b0;
                    if (cclk && !cclk_prev) begin
                        if (bits < m_len * 8) begin
                            mshr = {mshr[6:0], din};
                            bits = bits + 1;
                            if (bits % 8 == 0) rx[bits / 8 - 1] = mshr;
                            if (m_crck > 0 && bits == m_crck * 8) init_n = 1'b0;
                        end else begin
                            post_rises = post_rises + 1;
                            if (!din) post_zero = post_zero + 1;
                            if (m_dn >= 0 && post_rises >= m_dn) tdone = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
            if (cclk && !cclk_prev) begin
                if (lowrun > 0 && lowrun != HC) lowrun_bad = lowrun_bad + 1;
                lowrun = 0;
            end
        end
        cclk_prev = cclk;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int mode, input int n, input int i);
        if (mode == 1) begin
            case (i % 4)
                0: return 8'h80;
                1: return 8'h01;
                2: return 8'hFF;
                default: return 8'h00;
            endcase
        end
        return 8'((i * 53 + n * 29 + 7) & 255);
    endfunction

    // kind: 0 done, 1 fail at INIT-low wait, 2 fail at INIT-high wait, 3 fail in flush, 4 crc
    task automatic run_case(input int n, input int lo, input int hi, input int crck,
                            input int dn, input bit throttle, input int mode, input int kind);
        int res, exp_res, consumed, exp_cons, bad;
        m_len = n; m_lo = lo; m_hi = hi; m_crck = crck; m_dn = dn; thr = throttle;
        for (int i = 0; i < 16; i++) mem[i] = pat(mode, n, i);
        base = src_idx; src_end = src_idx + n;
        m_gen = m_gen + 1;
        @(negedge clk); @(negedge clk);
        len_drv = LW'(n); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int w = 0; w < 4000 && (cnt_done + cnt_fail + cnt_crc) == 0; w++) @(negedge clk);
        repeat (8) @(negedge clk);
        res = cnt_done * 100 + cnt_fail * 10 + cnt_crc;
        exp_res = (kind == 0) ? 100 : (kind == 4) ? 1 : 10;
        chk(res == exp_res, $sformatf("R10 result pulses len=%0d kind=%0d", n, kind), res, exp_res);
        consumed = src_idx - base;
        exp_cons = (kind == 0 || kind == 3) ? n : (kind == 4) ? crck : 0;
        chk(consumed == exp_cons, $sformatf("R5 bytes taken len=%0d kind=%0d", n, kind), consumed, exp_cons);
        chk(!prog && !sready && !cclk, "R1 quiet after run", {prog, sready, cclk}, 0);
        chk(lowrun_bad == 0, "R4 clock low phase length", lowrun_bad, 0);
        if (kind == 0 || kind == 3) begin
            bad = 0;
            for (int i = 0; i < n; i++) if (rx[i] !== mem[i]) bad = bad + 1;
            chk(bad == 0, $sformatf("R4 bytes MSB first len=%0d", n), bad, 0);
            chk(post_zero == 0, "R7 data high while flushing", post_zero, 0);
        end
        if (kind == 0) chk(post_rises >= dn, "R7 clocking until DONE", post_rises, dn);
        if (kind == 3) chk(post_rises > 0, "R8 flush clock before timeout", post_rises, 1);
        if (kind != 1) chk(t_prog_fall - t_init_low >= DLY, "R3 reset hold delay",
                           t_prog_fall - t_init_low, DLY);
        if (kind == 1) chk(t_fail - t_prog_rise >= TMO && t_fail - t_prog_rise <= TMO + 2,
                           "R2 INIT-low timeout window", t_fail - t_prog_rise, TMO);
        if (kind == 2) chk(t_fail - t_prog_fall >= TMO && t_fail - t_prog_fall <= TMO + 2,
                           "R3 INIT-high timeout window", t_fail - t_prog_fall, TMO);
        if (kind == 4) chk(cnt_crc == 1, $sformatf("R6 crc before byte %0d", crck), cnt_crc, 1);
        if (kind == 3) chk(cnt_fail == 1, "R8 DONE timeout", cnt_fail, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(!prog && !sready && !cclk && !din, "R1 state during reset", {prog, sready, cclk, din}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!prog && !sready && !cclk && !done_p && !fail_p && !crc_p, "R1 state after reset",
            {prog, sready, cclk, done_p, fail_p, crc_p}, 0);

        // R9: readback refused, no load started
        m_gen = m_gen + 1;
        @(negedge clk);
        rdbk = 1'b1;
        @(negedge clk);
        rdbk = 1'b0;
        chk(fail_p == 1'b1, "R9 readback refused next cycle", fail_p, 1);
        chk(prog == 1'b0, "R9 no reset request on readback", prog, 0);
        @(negedge clk);
        chk(fail_p == 1'b0, "R10 fail is one cycle", fail_p, 0);

        // length sweep, successful loads (R4, R5, R7)
        for (int n = 0; n <= 6; n++)
            run_case(n, n % 3, 2 + n % 4, -1, 1 + n % 3, bit'(n % 2), 0, 0);
        run_case(8, 1, 3, -1, 2, 1'b1, 1, 0);
        run_case(15, 0, 1, -1, 4, 1'b0, 0, 0);

        // R6: CRC error before each byte position of a 4-byte load
        for (int k = 0; k < 4; k++)
            run_case(4, 1, 2, k, 2, bit'(k % 2), 0, 4);

        // R2, R3, R8 timeouts
        run_case(3, -1, 2, -1, 2, 1'b0, 0, 1);
        run_case(3, 2, -1, -1, 2, 1'b0, 0, 2);
        run_case(2, 1, 2, -1, -1, 1'b0, 1, 3);
        run_case(0, 1, 2, -1, -1, 1'b0, 0, 3);

        // recovery after failures
        run_case(5, 2, 3, -1, 1, 1'b1, 1, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks = checks + 1;
        errors = errors + 1;
        $display("FAIL watchdog actual %0d expected %0d", 150000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule